// File: doc/BRIEF.md
# Sequential Single-Precision Square Root Unit

This block computes the square root of a 32-bit single-precision value for a processor whose datapath is only 16 bits wide. Software writes the operand into an internal register one 16-bit half at a time, then pulses `start`. The unit takes a snapshot of the operand and halves the unbiased exponent. When that exponent is odd it first doubles the mantissa. It then builds the mantissa root one bit per clock with a nonrestoring digit recurrence: the sign of the running remainder decides whether the next trial term is subtracted or added, and no restore step is ever taken.

After the last root bit, the block rounds the root to nearest-even. It uses one extra root bit and a sticky bit taken from the final remainder. It then packs the result and raises `done` for one cycle, exactly 26 clock cycles after the cycle in which `start` was accepted. The result is read back as two 16-bit halves.

Special operands take the same fixed latency. Zero and subnormal inputs give a zero of the same sign. Negative nonzero inputs give the quiet NaN and raise an invalid flag. NaN gives the quiet NaN. Positive infinity passes through unchanged.

Top module: `fsqrt_seq`

## Requirements
- R1: With `wr_en` high at a clock edge, `wr_hi`=1 writes `wr_data` into operand bits 31:16 and `wr_hi`=0 writes it into bits 15:0. The result appears as `res_hi` (bits 31:16) and `res_lo` (bits 15:0). Bit 31 is the sign, bits 30:23 are the biased exponent (bias 127) and bits 22:0 are the fraction.
- R2: If `start` is sampled high while `busy` is low, `busy` is high from the next cycle onward. `done` is a one-cycle pulse that is visible after the 26th rising edge following the sampling edge, and `busy` falls in that same cycle.
- R3: A `start` pulse that arrives while `busy` is high is ignored. It produces no extra `done` and does not change the result of the running operation.
- R4: For a positive normal input, the result equals the square root rounded to nearest, with ties to even.
- R5: For a positive normal input with biased exponent E, the result exponent is floor((E-127)/2)+127. When E-127 is odd, the mantissa is doubled before the root is taken. The result sign is 0.
- R6: An input whose exponent field is 0 (zero or subnormal) returns a zero with the input's sign, with `invalid`=0. The only negative result the block can produce is -0.
- R7: A negative input that is neither zero nor subnormal, including -infinity, returns 0x7FC00000 with `invalid`=1.
- R8: +infinity (0x7F800000) returns +infinity. Any NaN input returns 0x7FC00000 with `invalid`=0.
- R9: `res_hi`, `res_lo` and `invalid` change only in the cycle in which `done` is high, and hold their values until the next completion. Operand writes made after `start` has been accepted do not affect the running operation.
- R10: After reset, `busy`, `done`, `invalid`, `res_hi` and `res_lo` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one half of the operand register |
| wr_hi | input | 1 | 1 selects the upper half, 0 the lower half |
| wr_data | input | 16 | Operand half to write |
| start | input | 1 | Begin a square root on the current operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| invalid | output | 1 | Invalid-operation flag of the last result |
| res_hi | output | 16 | Result bits 31:16 |
| res_lo | output | 16 | Result bits 15:0 |

## Verification
The assertions check the timing contract on every cycle: `done` appears exactly 26 cycles after an accepted start and never at any other time, `busy` stays high throughout, and the outputs stay stable between completions. They also check two rules on the shape of every result: an invalid result is always the quiet NaN, and a negative result is always -0. Numerical correctness can only be shown by the bench's scenarios. These cover correct rounding, exponent halving for odd and even exponents, the extremes of the normal range, and the handling of each special class. The same holds for proving that a restart or an operand write during a run leaves the result untouched.

// File: rtl/fsqrt_pkg.sv
package fsqrt_pkg;
  typedef enum logic [2:0] {
    CLS_NORM,
    CLS_ZERO,
    CLS_INV,
    CLS_INF,
    CLS_NAN
  } sq_cls_e;
endpackage

// File: rtl/fsqrt_unpack.sv
module fsqrt_unpack
  import fsqrt_pkg::*;
#(
  parameter int MANT_W = 23,
  parameter int EXP_W  = 8
) (
  input  logic [EXP_W+MANT_W:0]       opnd,
  output sq_cls_e                     cls,
  output logic [2*(MANT_W+2)-1:0]     rad,
  output logic [EXP_W-1:0]            res_exp,
  output logic [EXP_W+MANT_W:0]       spec
);
  localparam int W  = EXP_W + MANT_W + 1;
  localparam int SW = EXP_W + 2;
  localparam logic signed [SW-1:0] BIAS_S = SW'((1 << (EXP_W - 1)) - 1);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MANT_W-1){1'b0}}};

  logic                    sgn;
  logic [EXP_W-1:0]        ex;
  logic [MANT_W-1:0]       fr;
  logic signed [SW-1:0]    eu, eh;
  logic                    odd;
  logic [MANT_W+2:0]       rad0;

  assign sgn = opnd[W-1];
  assign ex  = opnd[W-2:MANT_W];
  assign fr  = opnd[MANT_W-1:0];

  always_comb begin
    eu      = $signed({2'b00, ex}) - BIAS_S;
    odd     = eu[0];
    eh      = (eu - $signed({{(SW-1){1'b0}}, odd})) >>> 1;
    res_exp = EXP_W'(eh + BIAS_S);
    rad0    = odd ? {1'b1, fr, 2'b00} : {2'b01, fr, 1'b0};
    rad     = {rad0, {(MANT_W+1){1'b0}}};
  end

  always_comb begin
    if (&ex && |fr) begin
      cls  = CLS_NAN;
      spec = QNAN;
    end else if (ex == '0) begin
      cls  = CLS_ZERO;
      spec = {sgn, {(W-1){1'b0}}};
    end else if (sgn) begin
      cls  = CLS_INV;
      spec = QNAN;
    end else if (&ex) begin
      cls  = CLS_INF;
      spec = opnd;
    end else begin
      cls  = CLS_NORM;
      spec = '0;
    end
  end
endmodule

// File: rtl/fsqrt_step.sv
module fsqrt_step #(
  parameter int QW  = 25,
  parameter int RMW = 30
) (
  input  logic signed [RMW-1:0] rem,
  input  logic [QW-1:0]         root,
  input  logic [1:0]            pair,
  output logic signed [RMW-1:0] rem_n,
  output logic [QW-1:0]         root_n
);
  logic               neg;
  logic [RMW-1:0]     rem_sh;
  logic [RMW-1:0]     trial;

  always_comb begin
    neg    = rem[RMW-1];
    rem_sh = {rem[RMW-3:0], pair};
    trial  = {{(RMW-QW-2){1'b0}}, root, neg, 1'b1};
    rem_n  = neg ? $signed(rem_sh + trial) : $signed(rem_sh - trial);
    root_n = {root[QW-2:0], ~rem_n[RMW-1]};
  end
endmodule

// File: rtl/fsqrt_round.sv
module fsqrt_round #(
  parameter int MANT_W = 23,
  parameter int QW     = 25,
  parameter int RMW    = 30
) (
  input  logic [QW-1:0]         root,
  input  logic signed [RMW-1:0] rem,
  output logic [MANT_W-1:0]     mant,
  output logic                  carry
);
  logic [RMW-1:0] rem_fix;
  logic           sticky, up;
  logic [QW-1:0]  sum;

  always_comb begin
    rem_fix = rem[RMW-1] ? rem + {{(RMW-QW-1){1'b0}}, root, 1'b1} : rem;
    sticky  = |rem_fix;
    up      = root[0] & (sticky | root[1]);
    sum     = {1'b0, root[QW-1:1]} + {{(QW-1){1'b0}}, up};
    carry   = sum[QW-1];
    mant    = carry ? sum[QW-2:1] : sum[QW-3:0];
  end
endmodule

// File: rtl/fsqrt_seq.sv
module fsqrt_seq
  import fsqrt_pkg::*;
#(
  parameter int MANT_W = 23,
  parameter int EXP_W  = 8,
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              invalid,
  output logic [HALF_W-1:0] res_hi,
  output logic [HALF_W-1:0] res_lo
);
  localparam int W     = EXP_W + MANT_W + 1;
  localparam int QW    = MANT_W + 2;
  localparam int RMW   = QW + 5;
  localparam int XW    = 2 * QW;
  localparam int ITERS = QW;
  localparam int CW    = $clog2(ITERS + 1);

  logic [W-1:0]          opnd_q;
  logic [W-1:0]          res_q;
  logic                  busy_q, done_q, inv_q;
  logic [CW-1:0]         cnt_q;
  logic [XW-1:0]         x_q;
  logic signed [RMW-1:0] rem_q;
  logic [QW-1:0]         root_q;
  sq_cls_e               cls_q;
  logic [W-1:0]          spec_q;
  logic [EXP_W-1:0]      exp_q;

  sq_cls_e               cls_d;
  logic [XW-1:0]         rad_d;
  logic [EXP_W-1:0]      exp_d;
  logic [W-1:0]          spec_d;
  logic signed [RMW-1:0] rem_n;
  logic [QW-1:0]         root_n;
  logic [MANT_W-1:0]     mant_r;
  logic                  carry_r;

  fsqrt_unpack #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_unpack (
    .opnd(opnd_q), .cls(cls_d), .rad(rad_d), .res_exp(exp_d), .spec(spec_d)
  );

  fsqrt_step #(.QW(QW), .RMW(RMW)) u_step (
    .rem(rem_q), .root(root_q), .pair(x_q[XW-1:XW-2]),
    .rem_n(rem_n), .root_n(root_n)
  );

  fsqrt_round #(.MANT_W(MANT_W), .QW(QW), .RMW(RMW)) u_round (
    .root(root_q), .rem(rem_q), .mant(mant_r), .carry(carry_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      opnd_q <= '0;
    end else if (wr_en) begin
      if (wr_hi) opnd_q[W-1:HALF_W] <= wr_data;
      else       opnd_q[HALF_W-1:0] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      inv_q  <= 1'b0;
      res_q  <= '0;
      cnt_q  <= '0;
      x_q    <= '0;
      rem_q  <= '0;
      root_q <= '0;
      cls_q  <= CLS_ZERO;
      spec_q <= '0;
      exp_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        x_q    <= rad_d;
        rem_q  <= '0;
        root_q <= '0;
        cls_q  <= cls_d;
        spec_q <= spec_d;
        exp_q  <= exp_d;
      end else if (busy_q) begin
        if (cnt_q == CW'(ITERS)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          inv_q  <= (cls_q == CLS_INV);
          res_q  <= (cls_q == CLS_NORM)
                    ? {1'b0, exp_q + {{(EXP_W-1){1'b0}}, carry_r}, mant_r}
                    : spec_q;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
          rem_q  <= rem_n;
          root_q <= root_n;
          x_q    <= {x_q[XW-3:0], 2'b00};
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign invalid = inv_q;
  assign res_hi  = res_q[W-1:HALF_W];
  assign res_lo  = res_q[HALF_W-1:0];
endmodule

// File: rtl/fsqrt_seq_chk.sv
module fsqrt_seq_chk #(
  parameter int MANT_W = 23
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        invalid,
  input logic [15:0] res_hi,
  input logic [15:0] res_lo
);
  localparam int LAT = MANT_W + 3;

  logic       track;
  logic [6:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      track <= 1'b0;
      cnt   <= '0;
    end else if (start && !busy) begin
      track <= 1'b1;
      cnt   <= '0;
    end else if (track) begin
      if (cnt == 7'(LAT)) track <= 1'b0;
      else                cnt   <= cnt + 1'b1;
    end
  end

  AST_DONE_AT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (track && cnt == 7'(LAT)) |-> done); // R2
  AST_DONE_ONLY_AT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done |-> (track && cnt == 7'(LAT))); // R3
  AST_BUSY_WHILE_RUNNING: assert property (@(posedge clk) disable iff (rst)
    (track && cnt != 7'(LAT)) |-> busy); // R2
  AST_INVALID_IS_QNAN: assert property (@(posedge clk) disable iff (rst)
    (done && invalid) |-> ({res_hi, res_lo} == 32'h7FC0_0000)); // R7
  AST_NEG_ONLY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && res_hi[15]) |-> ({res_hi[14:0], res_lo} == 31'd0)); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(res_hi) && $stable(res_lo) && $stable(invalid))); // R9
endmodule

bind fsqrt_seq fsqrt_seq_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .invalid(invalid), .res_hi(res_hi), .res_lo(res_lo)
);

// File: tb/fsqrt_seq_tb_top.sv
module fsqrt_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_hi = 1'b0;
  logic [15:0] wr_data = '0;
  logic        start = 1'b0;
  logic        busy, done, invalid;
  logic [15:0] res_hi, res_lo;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] opnd;
    logic [31:0] res;
    logic        inv;
    int          t0;
    string       req;
  } exp_t;
  exp_t sb_q[$];

  fsqrt_seq dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
    .start(start), .busy(busy), .done(done), .invalid(invalid),
    .res_hi(res_hi), .res_lo(res_lo)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [32:0] model(input logic [31:0] a);
    logic        s;
    logic [7:0]  e;
    logic [22:0] f;
    logic [63:0] d, b;
    logic [10:0] de;
    logic [24:0] sum;
    logic        g, st, up;
    real         r;
    s = a[31]; e = a[30:23]; f = a[22:0];
    if (e == 8'hFF && f != 0) return {1'b0, 32'h7FC0_0000};
    if (e == 8'h00)           return {1'b0, s, 31'd0};
    if (s)                    return {1'b1, 32'h7FC0_0000};
    if (e == 8'hFF)           return {1'b0, a};
    d  = {1'b0, 11'(e + 896), f, 29'd0};
    r  = $sqrt($bitstoreal(d));
    b  = $realtobits(r);
    de = b[62:52];
    g  = b[28];
    st = |b[27:0];
    up = g & (st | b[29]);
    sum = {1'b0, 1'b1, b[51:29]} + {24'd0, up};
    if (sum[24]) return {1'b0, 1'b0, 8'(de - 11'd895), sum[23:1]};
    return {1'b0, 1'b0, 8'(de - 11'd896), sum[22:0]};
  endfunction

  task automatic write_op(input logic [31:0] a);
    @(negedge clk); wr_en = 1; wr_hi = 1; wr_data = a[31:16];
    @(negedge clk); wr_hi = 0; wr_data = a[15:0];
    @(negedge clk); wr_en = 0;
  endtask

  // Driver: pushes the expected item, pulses start, optionally disturbs the run.
  task automatic run_op(input logic [31:0] a, input string req, input bit disturb);
    exp_t it;
    logic [32:0] m;
    write_op(a);
    m = model(a);
    it.opnd = a; it.res = m[31:0]; it.inv = m[32]; it.t0 = cyc + 1; it.req = req;
    sb_q.push_back(it);
    start = 1;
    @(negedge clk); start = 0;
    if (disturb) begin
      repeat (4) @(negedge clk);
      wr_en = 1; wr_hi = 1; wr_data = 16'hC080;  // R9: write while busy
      start = 1;                                 // R3: restart while busy
      @(negedge clk); wr_en = 0; start = 0;
      repeat (22) @(negedge clk);
    end else begin
      repeat (27) @(negedge clk);
    end
  endtask

  // Monitor: compares each completion against the head of the scoreboard.
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R3 unexpected done", 64'(cyc), 64'd0);
      end else begin
        exp_t it;
        it = sb_q.pop_front();
        check(cyc - it.t0 == 26, "R2 latency", 64'(cyc - it.t0), 64'd26);
        check({res_hi, res_lo} == it.res, it.req, {32'd0, res_hi, res_lo},
              {32'd0, it.res});
        check(invalid == it.inv, {it.req, " invalid"}, 64'(invalid), 64'(it.inv));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 64'(cyc), 64'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10: reset state
    check(!busy && !done && !invalid && res_hi == 0 && res_lo == 0, "R10 reset",
          {29'd0, busy, done, invalid, res_hi, res_lo}, 64'd0);

    run_op(32'h4080_0000, "R4 sqrt(4)=2", 0);
    run_op(32'h3F80_0000, "R4 sqrt(1)=1", 0);
    run_op(32'h4000_0000, "R4 sqrt(2) rounded", 0);
    run_op(32'h4110_0000, "R5 odd exponent sqrt(9)", 0);
    run_op(32'h3E80_0000, "R5 negative even exponent sqrt(0.25)", 0);
    run_op(32'h3F00_0000, "R5 negative odd exponent sqrt(0.5)", 0);
    run_op(32'h7F7F_FFFF, "R4 largest normal", 0);
    run_op(32'h0080_0000, "R5 smallest normal", 0);
    run_op(32'h4040_0000, "R4 sqrt(3) rounding", 0);
    run_op(32'h0000_0000, "R6 +0", 0);
    run_op(32'h8000_0000, "R6 -0", 0);
    run_op(32'h0000_0001, "R6 subnormal flush", 0);
    run_op(32'h8040_0000, "R6 negative subnormal flush", 0);
    run_op(32'hC080_0000, "R7 negative normal", 0);
    run_op(32'hFF80_0000, "R7 -inf", 0);
    run_op(32'h7F80_0000, "R8 +inf", 0);
    run_op(32'h7FA0_0001, "R8 signalling NaN", 0);
    run_op(32'hFFC0_0000, "R8 negative NaN", 0);
    run_op(32'h4110_0000, "R3 R9 disturbed run sqrt(9)", 1);

    // R9: result held after completion while operand changes
    held = {res_hi, res_lo};
    write_op(32'h1234_5678);
    repeat (5) @(negedge clk);
    check({res_hi, res_lo} == held, "R9 hold", {32'd0, res_hi, res_lo}, {32'd0, held});

    // R1: half order matters: swapping halves changes the operand
    run_op(32'h4080_0000, "R1 halves", 0);

    lcg = 32'h1357_9BDF;
    for (int i = 0; i < 150; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (lcg[30:23] == 8'h00 || lcg[30:23] == 8'hFF) lcg[30:23] = 8'h80;
      run_op({(i % 10 == 9) ? 1'b1 : 1'b0, lcg[30:0]},
             (i % 10 == 9) ? "R7 random negative" : "R4 R5 random normal", 0);
    end

    repeat (5) @(negedge clk);
    check(sb_q.size() == 0, "R2 pending results", 64'(sb_q.size()), 64'd0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule